// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block follows the open-row state of a single DRAM bank and works out which command the request now assigned to that bank needs next. The bank is either closed (precharged) or has one row open. A pending request on a closed bank asks for an activate of its row. On an open bank, a request for the open row asks for a read or a write, and a request for any other row asks for a precharge.

An outside timing counter raises one "constraint met" bit for each command type. The block marks its proposal ready only when the bit for the proposed command is set. An arbiter picks among the ready proposals of all banks and acknowledges the one it issues. The bank state changes only on that acknowledge. An issued read or write retires the request through a one-cycle pop strobe. A request whose operation code is neither read nor write sets an error bit that stays set until reset.

The proposal, its ready flag, tag, row and the error bit are all registered. They show the inputs from the previous clock edge, evaluated against the bank state after any acknowledge taken at that same edge.

Top module: `bank_cmd_fsm`

## Requirements
- R1: While `rst` is high and at the first edge after it, `cmd_o` is NOP (0), `cmd_rdy` and `cmd_err` are 0, and the bank is closed.
- R2: With the bank closed and `req_valid` high, the next registered proposal is ACT (1), and `cmd_row` holds the request row.
- R3: With the bank open and `req_row` equal to the open row, the proposal is RD (2) for `req_op` = 2'b01 and WR (3) for `req_op` = 2'b10.
- R4: With the bank open and `req_row` different from the open row, the proposal is PRE (4).
- R5: `cmd_rdy` is 1 only when the `tmg_ok` bit of the proposed command was 1 at the same edge (bit 0 ACT, bit 1 RD, bit 2 WR, bit 3 PRE). Without that bit the command is still shown, with `cmd_rdy` 0.
- R6: With `req_valid` low the proposal is NOP and `cmd_rdy` is 0.
- R7: An acknowledged ACT opens the bank with the row from `cmd_row`. An acknowledged PRE closes it. The proposal after the acknowledge edge already reflects the new state.
- R8: An acknowledged RD or WR pulses `req_pop` combinationally in the acknowledge cycle. The next proposal is NOP. The bank stays open, so a later request to the same row proposes RD or WR directly.
- R9: A pending request with `req_op` of 2'b00 or 2'b11 sets `cmd_err`. It stays 1 until reset. An open-bank hit with such a code proposes NOP.
- R10: `issue_ack` while `cmd_rdy` is 0 has no effect on the bank state.
- R11: `cmd_tag` shows the `req_tag` sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is pending for this bank |
| req_op | input | 2 | 01 read, 10 write, other codes invalid |
| req_row | input | ROW_W | Row the request targets |
| req_tag | input | TAG_W | Request identifier |
| tmg_ok | input | 4 | Timing met per command: ACT, RD, WR, PRE in bits 0..3 |
| issue_ack | input | 1 | Arbiter issued the current proposal |
| cmd_o | output | 3 | Proposed command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE |
| cmd_rdy | output | 1 | Proposal may be issued |
| cmd_tag | output | TAG_W | Tag of the request behind the proposal |
| cmd_row | output | ROW_W | Row of the request behind the proposal |
| req_pop | output | 1 | Request retired this cycle |
| cmd_err | output | 1 | Sticky invalid-operation flag |

## Verification
Two things can happen at the same edge: an acknowledge that changes the bank state, and the computation of the next proposal. If the proposal were taken from the old state, it would repeat a stale command. The bench acknowledges ACT, PRE and RD/WR while keeping the same request on the inputs. The scoreboard expects the very next registered proposal to follow from the post-acknowledge state: RD right after ACT, ACT right after PRE, NOP right after a retire. The bench also acknowledges a proposal that is not ready and expects the bank state to stay unchanged.

// File: rtl/bank_cmd_pkg.sv
package bank_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } bank_cmd_e;

  typedef enum logic {
    BK_CLOSED = 1'b0,
    BK_OPEN   = 1'b1
  } bank_st_e;

  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam int         TMG_W    = 4;
endpackage

// File: rtl/bank_row_cmp.sv
module bank_row_cmp #(
  parameter int ROW_W = 14
) (
  input  logic [ROW_W-1:0] row_a,
  input  logic [ROW_W-1:0] row_b,
  output logic             hit
);
  assign hit = (row_a == row_b);
endmodule

// File: rtl/bank_state_reg.sv
module bank_state_reg
  import bank_cmd_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  bank_cmd_e        fire_cmd,
  input  logic [ROW_W-1:0] fire_row,
  output bank_st_e         st_q,
  output logic [ROW_W-1:0] row_q,
  output bank_st_e         st_n,
  output logic [ROW_W-1:0] row_n
);
  always_comb begin
    st_n  = st_q;
    row_n = row_q;
    if (fire) begin
      if (fire_cmd == CMD_ACT) begin
        st_n  = BK_OPEN;
        row_n = fire_row;
      end else if (fire_cmd == CMD_PRE) begin
        st_n  = BK_CLOSED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= BK_CLOSED;
      row_q <= '0;
    end else begin
      st_q  <= st_n;
      row_q <= row_n;
    end
  end
endmodule

// File: rtl/bank_cmd_sel.sv
module bank_cmd_sel
  import bank_cmd_pkg::*;
(
  input  logic             pend,
  input  logic [1:0]       op,
  input  bank_st_e         st,
  input  logic             hit,
  input  logic [TMG_W-1:0] tmg_ok,
  output bank_cmd_e        cmd,
  output logic             rdy,
  output logic             bad_op
);
  logic tmg_sel;

  assign bad_op = pend && (op != OP_READ) && (op != OP_WRITE);

  always_comb begin
    cmd = CMD_NOP;
    if (pend) begin
      if (st == BK_CLOSED)   cmd = CMD_ACT;
      else if (!hit)         cmd = CMD_PRE;
      else if (op == OP_READ)  cmd = CMD_RD;
      else if (op == OP_WRITE) cmd = CMD_WR;
    end
  end

  always_comb begin
    case (cmd)
      CMD_ACT: tmg_sel = tmg_ok[0];
      CMD_RD:  tmg_sel = tmg_ok[1];
      CMD_WR:  tmg_sel = tmg_ok[2];
      CMD_PRE: tmg_sel = tmg_ok[3];
      default: tmg_sel = 1'b0;
    endcase
  end

  assign rdy = tmg_sel;
endmodule

// File: rtl/bank_cmd_fsm.sv
module bank_cmd_fsm
  import bank_cmd_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [ROW_W-1:0] req_row,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [3:0]       tmg_ok,
  input  logic             issue_ack,
  output logic [2:0]       cmd_o,
  output logic             cmd_rdy,
  output logic [TAG_W-1:0] cmd_tag,
  output logic [ROW_W-1:0] cmd_row,
  output logic             req_pop,
  output logic             cmd_err
);
  bank_cmd_e        cmd_cur;
  logic             fire;
  logic             retire;
  bank_st_e         st_q;
  bank_st_e         st_n;
  logic [ROW_W-1:0] open_row;
  logic [ROW_W-1:0] row_n;
  logic             hit;
  bank_cmd_e        nxt_cmd;
  logic             nxt_rdy;
  logic             bad_op;

  assign cmd_cur = bank_cmd_e'(cmd_o);
  assign fire    = issue_ack && cmd_rdy && (cmd_cur != CMD_NOP);
  assign retire  = fire && ((cmd_cur == CMD_RD) || (cmd_cur == CMD_WR));
  assign req_pop = retire;

  bank_state_reg #(.ROW_W(ROW_W)) u_state (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .fire_cmd (cmd_cur),
    .fire_row (cmd_row),
    .st_q     (st_q),
    .row_q    (open_row),
    .st_n     (st_n),
    .row_n    (row_n)
  );

  bank_row_cmp #(.ROW_W(ROW_W)) u_cmp (
    .row_a (req_row),
    .row_b (row_n),
    .hit   (hit)
  );

  bank_cmd_sel u_sel (
    .pend   (req_valid && !retire),
    .op     (req_op),
    .st     (st_n),
    .hit    (hit),
    .tmg_ok (tmg_ok),
    .cmd    (nxt_cmd),
    .rdy    (nxt_rdy),
    .bad_op (bad_op)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o   <= CMD_NOP;
      cmd_rdy <= 1'b0;
      cmd_tag <= '0;
      cmd_row <= '0;
      cmd_err <= 1'b0;
    end else begin
      cmd_o   <= nxt_cmd;
      cmd_rdy <= nxt_rdy;
      cmd_tag <= req_tag;
      cmd_row <= req_row;
      cmd_err <= cmd_err | bad_op;
    end
  end

  AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (cmd_cur == CMD_ACT) |-> (st_q == BK_CLOSED)); // R2
  AST_ACCESS_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    ((cmd_cur == CMD_RD) || (cmd_cur == CMD_WR)) |-> (st_q == BK_OPEN && cmd_row == open_row)); // R3
  AST_PRE_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    (cmd_cur == CMD_PRE) |-> (st_q == BK_OPEN && cmd_row != open_row)); // R4
  AST_RDY_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_rdy |-> (cmd_cur != CMD_NOP)); // R5
  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (cmd_cur == CMD_NOP && !cmd_rdy)); // R6
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (fire && cmd_cur == CMD_ACT) |=> (st_q == BK_OPEN && open_row == $past(cmd_row))); // R7
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (fire && cmd_cur == CMD_PRE) |=> (st_q == BK_CLOSED)); // R7
  AST_RETIRE_KEEPS_OPEN: assert property (@(posedge clk) disable iff (rst)
    retire |=> (st_q == BK_OPEN && $stable(open_row) && cmd_cur == CMD_NOP)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err); // R9
  AST_NO_FIRE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(st_q) && $stable(open_row))); // R10
endmodule

// File: tb/bank_cmd_fsm_tb.sv
module bank_cmd_fsm_tb;
  localparam int ROW_W = 8;
  localparam int TAG_W = 4;
  localparam int ITEM_W = 3 + 1 + 1 + TAG_W + ROW_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [1:0]       req_op = 2'b00;
  logic [ROW_W-1:0] req_row = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [3:0]       tmg_ok = 4'h0;
  logic             issue_ack = 1'b0;
  logic [2:0]       cmd_o;
  logic             cmd_rdy;
  logic [TAG_W-1:0] cmd_tag;
  logic [ROW_W-1:0] cmd_row;
  logic             req_pop;
  logic             cmd_err;

  int checks = 0;
  int errors = 0;
  logic [ITEM_W-1:0] exp_q[$];
  string             req_q[$];
  bit                done = 1'b0;

  always #2.5 clk = ~clk;

  bank_cmd_fsm #(.ROW_W(ROW_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .req_tag(req_tag), .tmg_ok(tmg_ok),
    .issue_ack(issue_ack), .cmd_o(cmd_o), .cmd_rdy(cmd_rdy),
    .cmd_tag(cmd_tag), .cmd_row(cmd_row), .req_pop(req_pop), .cmd_err(cmd_err)
  );

  task automatic check_bit(string rq, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", rq, act, exp);
    end
  endtask

  // driver: set inputs at negedge, push the registered result expected after the next edge
  task automatic step(string rq, logic v, logic [1:0] op, logic [ROW_W-1:0] row,
                      logic [TAG_W-1:0] tag, logic [3:0] tm, logic ack,
                      logic pop_exp, logic [2:0] ecmd, logic erdy, logic eerr);
    @(negedge clk);
    req_valid = v; req_op = op; req_row = row; req_tag = tag;
    tmg_ok = tm; issue_ack = ack;
    #1;
    check_bit({rq, " req_pop"}, req_pop, pop_exp);
    exp_q.push_back({ecmd, erdy, eerr, tag, row});
    req_q.push_back(rq);
  endtask

  // monitor: compare registered outputs shortly after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [ITEM_W-1:0] e;
      logic [ITEM_W-1:0] a;
      string rq;
      e  = exp_q.pop_front();
      rq = req_q.pop_front();
      a  = {cmd_o, cmd_rdy, cmd_err, cmd_tag, cmd_row};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: got cmd=%0d rdy=%0b err=%0b tag=%0h row=%0h expected cmd=%0d rdy=%0b err=%0b tag=%0h row=%0h",
                 rq, a[ITEM_W-1 -: 3], a[ITEM_W-4], a[ITEM_W-5], a[ROW_W +: TAG_W], a[ROW_W-1:0],
                 e[ITEM_W-1 -: 3], e[ITEM_W-4], e[ITEM_W-5], e[ROW_W +: TAG_W], e[ROW_W-1:0]);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_bit("R1 cmd nop", cmd_o == 3'd0, 1'b1);
    check_bit("R1 rdy", cmd_rdy, 1'b0);
    check_bit("R1 err", cmd_err, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    step("R6 idle",             0, 2'b01, 8'h05, 4'h0, 4'hF, 0, 0, 3'd0, 0, 0);
    step("R2 R5 act no timing", 1, 2'b01, 8'h05, 4'h1, 4'h0, 0, 0, 3'd1, 0, 0);
    step("R2 R11 act ready",    1, 2'b01, 8'h05, 4'h1, 4'hF, 0, 0, 3'd1, 1, 0);
    step("R7 R3 act ack -> rd", 1, 2'b01, 8'h05, 4'h1, 4'hF, 1, 0, 3'd2, 1, 0);
    step("R8 rd retire",        1, 2'b01, 8'h05, 4'h1, 4'hF, 1, 1, 3'd0, 0, 0);
    step("R8 R3 wr on open",    1, 2'b10, 8'h05, 4'h2, 4'hF, 0, 0, 3'd3, 1, 0);
    step("R8 wr retire",        1, 2'b10, 8'h05, 4'h2, 4'hF, 1, 1, 3'd0, 0, 0);
    step("R4 R5 miss pre",      1, 2'b01, 8'h09, 4'h3, 4'h7, 0, 0, 3'd4, 0, 0);
    step("R10 ack not ready",   1, 2'b01, 8'h09, 4'h3, 4'h7, 1, 0, 3'd4, 0, 0);
    step("R4 pre ready",        1, 2'b01, 8'h09, 4'h3, 4'hF, 0, 0, 3'd4, 1, 0);
    step("R7 pre ack -> act",   1, 2'b01, 8'h09, 4'h3, 4'hF, 1, 0, 3'd1, 1, 0);
    step("R7 act ack -> rd",    1, 2'b01, 8'h09, 4'h3, 4'hF, 1, 0, 3'd2, 1, 0);
    step("R8 rd retire 2",      1, 2'b01, 8'h09, 4'h3, 4'hF, 1, 1, 3'd0, 0, 0);
    step("R9 bad op",           1, 2'b00, 8'h09, 4'h4, 4'hF, 0, 0, 3'd0, 0, 1);
    step("R9 sticky",           0, 2'b01, 8'h09, 4'h5, 4'hF, 0, 0, 3'd0, 0, 1);
    @(negedge clk);
    req_valid = 1'b0; issue_ack = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule